// File: doc/BRIEF.md
# Per-category transmit loopback selector

This block sits in the transmit path of a slave-side radio-link framer. Every outgoing word is taken either from the received stream or from the local generator. Which source wins depends on a 3-bit loop code and on the category of the word. A word can be IQ data, fast management, vendor-specific control, or other control.

The received and local streams arrive aligned to the same word position. One set of position tags describes both. The word index inside the basic frame marks index 0 as the control word and all other indices as IQ data. The hyperframe index (0 to 255) numbers the basic frames, and so also the control words.

Two inclusive index ranges classify the words. One range marks fast management, and it covers both the control word and the data words of those basic frames. The other range marks vendor-specific control words. The choice is registered, which adds exactly one cycle of latency.

Top module: `loop_word_sel`

## Requirements
- R1: While rst_n is low, tx_word and tx_valid are zero, and every control behaves as zero.
- R2: With tx_en high, tx_valid equals in_valid from one cycle earlier, and tx_word carries the selected word of that cycle.
- R3: Loop code 000 sends the local word. Reserved codes 101, 110 and 111 also send the local word.
- R4: Loop code 001 sends the received word at every word position.
- R5: Loop code 010 sends the received word when word_ix is not 0 (IQ data). It sends the local word when word_ix is 0 (control word).
- R6: Loop code 011 sends the received word, control or data, for any basic frame whose hf_ix lies in [mgmt_lo, mgmt_hi]. All other words are local.
- R7: Loop code 100 sends the received word only for control words (word_ix 0) whose hf_ix lies in [mgmt_lo, mgmt_hi] or in [vend_lo, vend_hi]. Data words and other control words are local.
- R8: While synced is low, the output is the local word whatever the loop code.
- R9: While is_slave is low (master configuration), the loop code is ignored and the output is the local word.
- R10: While phy_loop is high, the loop code is ignored and the output is the local word.
- R11: While tx_en is low, the next tx_word is zero and the next tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word present on both streams |
| word_ix | input | $clog2(BF_WORDS) | Word position in basic frame, 0 = control word |
| hf_ix | input | $clog2(HF_CNT) | Basic-frame index within hyperframe |
| rx_word | input | W | Received word |
| loc_word | input | W | Locally generated word |
| loop_sel | input | 3 | Loop code |
| synced | input | 1 | Frame synchronization reached |
| is_slave | input | 1 | Slave configuration |
| phy_loop | input | 1 | Physical-layer loop active, overrides loop code |
| tx_en | input | 1 | Transmit enable |
| mgmt_lo | input | $clog2(HF_CNT) | First fast-management index |
| mgmt_hi | input | $clog2(HF_CNT) | Last fast-management index |
| vend_lo | input | $clog2(HF_CNT) | First vendor-specific index |
| vend_hi | input | $clog2(HF_CNT) | Last vendor-specific index |
| tx_valid | output | 1 | Output word present |
| tx_word | output | W | Transmitted word |

## Verification
The assertions assume the controls are stable within a word and the two range pairs are well ordered (lo not above hi). They also assume rx_word and loc_word describe the same position as the tags. The stimulus holds each configuration constant over a full sweep of the hyperframe. It walks every hf_ix with word indices 0 to 3 and keeps the ranges fixed and ordered. It draws both data words and in_valid at random, so the received and local sources are almost always distinguishable at the output.

// File: rtl/loop_word_sel.sv
module loop_word_sel #(
  parameter int W        = 32,
  parameter int BF_WORDS = 16,
  parameter int HF_CNT   = 256,
  localparam int WIX_W   = $clog2(BF_WORDS),
  localparam int HIX_W   = $clog2(HF_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIX_W-1:0] word_ix,
  input  logic [HIX_W-1:0] hf_ix,
  input  logic [W-1:0]     rx_word,
  input  logic [W-1:0]     loc_word,
  input  logic [2:0]       loop_sel,
  input  logic             synced,
  input  logic             is_slave,
  input  logic             phy_loop,
  input  logic             tx_en,
  input  logic [HIX_W-1:0] mgmt_lo,
  input  logic [HIX_W-1:0] mgmt_hi,
  input  logic [HIX_W-1:0] vend_lo,
  input  logic [HIX_W-1:0] vend_hi,
  output logic             tx_valid,
  output logic [W-1:0]     tx_word
);

  localparam logic [2:0] L_NONE = 3'b000;
  localparam logic [2:0] L_FULL = 3'b001;
  localparam logic [2:0] L_IQ   = 3'b010;
  localparam logic [2:0] L_MGMT = 3'b011;
  localparam logic [2:0] L_MV   = 3'b100;

  logic is_ctl, in_mgmt, in_vend, loop_ok, take_rx;

  assign is_ctl  = (word_ix == '0);
  assign in_mgmt = (hf_ix >= mgmt_lo) && (hf_ix <= mgmt_hi);
  assign in_vend = (hf_ix >= vend_lo) && (hf_ix <= vend_hi);
  assign loop_ok = is_slave && synced && !phy_loop;

  always_comb begin
    take_rx = 1'b0;
    if (loop_ok) begin
      unique case (loop_sel)
        L_FULL:  take_rx = 1'b1;
        L_IQ:    take_rx = !is_ctl;
        L_MGMT:  take_rx = in_mgmt;
        L_MV:    take_rx = is_ctl && (in_mgmt || in_vend);
        default: take_rx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else begin
      tx_valid <= tx_en && in_valid;
      tx_word  <= !tx_en ? '0 : (take_rx ? rx_word : loc_word);
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_word == '0) && !tx_valid);

  // R11
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tx_word == '0) && !tx_valid);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> tx_valid == $past(in_valid));

  // R8
  unsynced_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !synced) |=> tx_word == $past(loc_word));

  // R9
  master_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !is_slave) |=> tx_word == $past(loc_word));

  // R10
  phy_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && phy_loop) |=> tx_word == $past(loc_word));

  // R3
  no_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && (loop_sel == L_NONE || loop_sel > L_MV)) |=> tx_word == $past(loc_word));

  // R4
  full_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && is_slave && synced && !phy_loop && loop_sel == L_FULL)
      |=> tx_word == $past(rx_word));

  // R5
  iq_ctl_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && loop_sel == L_IQ && word_ix == '0) |=> tx_word == $past(loc_word));

  // R7
  mv_data_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && loop_sel == L_MV && word_ix != '0) |=> tx_word == $past(loc_word));

endmodule

// File: tb/loop_word_sel_tb.sv
module loop_word_sel_tb_top;
  localparam int W = 32;
  localparam int WIX_W = 4;
  localparam int HIX_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, synced, is_slave, phy_loop, tx_en, tx_valid;
  logic [WIX_W-1:0] word_ix;
  logic [HIX_W-1:0] hf_ix, mgmt_lo, mgmt_hi, vend_lo, vend_hi;
  logic [W-1:0] rx_word, loc_word, tx_word;
  logic [2:0] loop_sel;

  int compared = 0;
  int mismatched = 0;

  loop_word_sel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_ix(word_ix), .hf_ix(hf_ix),
    .rx_word(rx_word), .loc_word(loc_word), .loop_sel(loop_sel), .synced(synced),
    .is_slave(is_slave), .phy_loop(phy_loop), .tx_en(tx_en), .mgmt_lo(mgmt_lo),
    .mgmt_hi(mgmt_hi), .vend_lo(vend_lo), .vend_hi(vend_hi),
    .tx_valid(tx_valid), .tx_word(tx_word));

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] want);
    compared++;
    if (got !== want) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // category: 0 plain IQ, 1 mgmt IQ, 2 mgmt ctl, 3 vendor ctl, 4 other ctl
  function automatic int category(int w, int h);
    bit m = (h >= mgmt_lo) && (h <= mgmt_hi);
    bit v = (h >= vend_lo) && (h <= vend_hi);
    if (w != 0) return m ? 1 : 0;
    if (m) return 2;
    return v ? 3 : 4;
  endfunction

  task automatic run_cfg(int mode, bit sy, bit sl, bit ph, bit en);
    loop_sel = 3'(mode); synced = sy; is_slave = sl; phy_loop = ph; tx_en = en;
    for (int h = 0; h < 256; h++) begin
      for (int w = 0; w < 4; w++) begin
        logic [W-1:0] exp_w;
        logic exp_v;
        string tag;
        int c;
        bit use_rx;
        word_ix = WIX_W'(w); hf_ix = HIX_W'(h);
        rx_word = $urandom; loc_word = $urandom;
        if (rx_word == loc_word) loc_word = ~rx_word;
        in_valid = ($urandom % 8) != 0;
        c = category(w, h);
        use_rx = 0;
        case (mode)
          1: begin use_rx = 1; tag = "R4"; end
          2: begin use_rx = (c <= 1); tag = "R5"; end
          3: begin use_rx = (c == 1 || c == 2); tag = "R6"; end
          4: begin use_rx = (c == 2 || c == 3); tag = "R7"; end
          default: tag = "R3";
        endcase
        if (!sy) begin use_rx = 0; tag = "R8"; end
        if (!sl) begin use_rx = 0; tag = "R9"; end
        if (ph) begin use_rx = 0; tag = "R10"; end
        exp_w = use_rx ? rx_word : loc_word;
        exp_v = in_valid;
        if (!en) begin exp_w = '0; exp_v = 0; tag = "R11"; end
        @(negedge clk);
        check(tag, tx_word, exp_w);
        check(en ? "R2" : "R11", W'(tx_valid), W'(exp_v));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 1; word_ix = 0; hf_ix = 0; rx_word = '1; loc_word = '1;
    loop_sel = 3'd1; synced = 1; is_slave = 1; phy_loop = 0; tx_en = 1;
    mgmt_lo = 8'd10; mgmt_hi = 8'd20; vend_lo = 8'd64; vend_hi = 8'd79;
    repeat (3) @(negedge clk);
    check("R1", tx_word, '0);
    check("R1", W'(tx_valid), '0);
    rst_n = 1;
    for (int m = 0; m < 8; m++) run_cfg(m, 1, 1, 0, 1);
    run_cfg(1, 0, 1, 0, 1);
    run_cfg(1, 1, 0, 0, 1);
    run_cfg(1, 1, 1, 1, 1);
    run_cfg(1, 1, 1, 0, 0);
    run_cfg(4, 1, 1, 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule